// File: doc/BRIEF.md
# Tri-Level Strap Pin Configuration Latch

This block sits between seven configuration strap pins and a converter core. Each strap pin can be tied high, tied low or left open. After every reset the block senses each pin by driving a weak high pulse and then a weak low pulse through the pad's output control. It samples the returned level at the end of each pulse. A pin that follows the weak driver is open. A pin that ignores it is tied. The result is one three-valued code for each pin.

When both samples have been taken, the block decodes the codes into a converter configuration and latches it. The configuration covers the programming mode, speed, filter, oversampling ratio, lane arrangement, frame header and the fixed hardware-mode defaults. The block then raises `done`. From that point it stops sensing and holds every pin that was found open strongly low. It ignores any later change on the pins until the next reset.

Sensing runs on all seven pins in parallel. The pulse length is set by the parameter `PULSE_CYC`.

Top module: `strap_sense_top`

## Requirements
- R1: Pin index order is 0 mode, 1 speed, 2 filter, 3 ratio-low, 4 ratio-high, 5 lanes, 6 header. Each pin is classified as 0 (tied low) when both samples are low, 1 (tied high) when both are high, and 2 (floating) when the samples differ.
- R2: The pins are sensed only after reset. Pin changes after `done` leave every configuration output and `pad_hold_low` unchanged until the next reset.
- R3: Sensing uses only the weak driver.
  - Reset releases on a clock edge, called edge 0.
  - Through rising edge `PULSE_CYC`, every `pad_drv_en` bit is 1 and every `pad_drv_val` bit is 1.
  - Through edge 2*`PULSE_CYC`, every `pad_drv_en` bit is 1 and every `pad_drv_val` bit is 0.
  - `done` rises at edge 2*`PULSE_CYC`+1, after which `pad_drv_en` is all 0.
- R4: After `done`, `pad_hold_low[i]` is 1 exactly for the pins classified floating. Before `done` it is all 0.
- R5: Mode pin code 1 selects software programming.
  - `prog_spi` is 1.
  - All strap-derived fields keep their reset values.
  - `buf_en`, `clk_ext`, `ref_high` and `vcm_en` are 0.
  - With code 0 or 2, `prog_spi` is 0 and `buf_en` equals 1 only for code 0.
- R6: Until `done`, the outputs hold their reset values: `prog_spi`, `buf_en`, `clk_ext`, `ref_high` and `vcm_en` are 0, every select is 0, and `osr_ratio` is 32.
- R7: In hardware mode, `speed_sel`, `filt_sel`, `lane_sel` and `hdr_sel` carry the code of the speed, filter, lanes and header pins.
  - `speed_sel`: 0 low, 1 maximum, 2 middle.
  - `filt_sel`: 0 wideband, 1 sinc4, 2 sinc4 followed by sinc1.
  - `lane_sel`: 0 all lanes, 1 one lane, 2 two lanes.
  - `hdr_sel`: 0 data only, 1 status plus data, 2 status plus data plus CRC.
- R8: In hardware mode, `osr_ratio` is taken from the ratio index, which is 3*code(ratio-high) + code(ratio-low), over indices 0..8.
  - Wideband: 32, 64, 128, 256, 512, 1024, 2048, 4096, 4096.
  - Sinc4: 12, 16, 24, 32, 64, 128, 256, 1024, 4096.
  - Sinc4 plus sinc1: 64, 128, 320, 640, 1280, 3200, 6400, 12800, 32000.
- R9: In hardware mode after `done`, `clk_ext`, `ref_high` and `vcm_en` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts a new sensing pass |
| pad_in | input | 7 | Level read back from each strap pad |
| pad_drv_en | output | 7 | Weak driver enable per pad |
| pad_drv_val | output | 7 | Weak driver level per pad |
| pad_hold_low | output | 7 | Strong low drive for pads found floating |
| done | output | 1 | Configuration latched |
| prog_spi | output | 1 | Software programming selected |
| buf_en | output | 1 | Input buffers enabled (hardware mode) |
| speed_sel | output | 2 | Speed code |
| filt_sel | output | 2 | Filter code |
| osr_ratio | output | 16 | Decoded oversampling ratio |
| lane_sel | output | 2 | Data lane arrangement code |
| hdr_sel | output | 2 | Frame header code |
| clk_ext | output | 1 | External clock mode default |
| ref_high | output | 1 | High reference range default |
| vcm_en | output | 1 | Common-mode output enabled default |

## Verification
The hardest situation to reach is a strap change after `done` that would produce a different decode if it were sensed again. It is especially hard when an open pin is now pulled high against the block's own strong low hold. The bench walks all 2187 strap combinations through a fresh reset each. For a random subset it then rewrites every pad to a new random state, waits, and confirms that the latched outputs and hold pattern still match the original combination. The next combination's reset shows that sensing is live again.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int NUM_PINS  = 7;
    localparam int PIN_MODE  = 0;
    localparam int PIN_SPEED = 1;
    localparam int PIN_FILT  = 2;
    localparam int PIN_RLO   = 3;
    localparam int PIN_RHI   = 4;
    localparam int PIN_LANES = 5;
    localparam int PIN_HDR   = 6;
    localparam int RATIO_W   = 16;

    typedef enum logic [1:0] {
        TRI_LO = 2'd0,
        TRI_HI = 2'd1,
        TRI_FL = 2'd2
    } tri_e;

    typedef enum logic [1:0] {
        PH_HI   = 2'd0,
        PH_LO   = 2'd1,
        PH_FIN  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic               spi;
        logic               buf_en;
        tri_e               speed;
        tri_e               filt;
        logic [RATIO_W-1:0] osr;
        tri_e               lanes;
        tri_e               hdr;
        logic               clk_ext;
        logic               ref_high;
        logic               vcm_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        spi:      1'b0,
        buf_en:   1'b0,
        speed:    TRI_LO,
        filt:     TRI_LO,
        osr:      16'd32,
        lanes:    TRI_LO,
        hdr:      TRI_LO,
        clk_ext:  1'b0,
        ref_high: 1'b0,
        vcm_en:   1'b0
    };

    // Two samples: one at the end of the weak-high pulse, one at the end of the weak-low pulse.
    function automatic tri_e classify(input logic hi_smp, input logic lo_smp);
        if (hi_smp && lo_smp)
            return TRI_HI;
        else if (!hi_smp && !lo_smp)
            return TRI_LO;
        else
            return TRI_FL;
    endfunction

    function automatic logic [3:0] pair_index(input tri_e msb, input tri_e lsb);
        return ({2'b00, msb} * 4'd3) + {2'b00, lsb};
    endfunction

    function automatic logic [RATIO_W-1:0] osr_lookup(input tri_e filt, input logic [3:0] idx);
        logic [RATIO_W-1:0] r;
        r = 16'd32;
        case (filt)
            TRI_LO: begin
                // Wideband doubles per step and saturates at the top two entries.
                r = 16'd32 << ((idx > 4'd7) ? 4'd7 : idx);
            end
            TRI_HI: begin
                case (idx)
                    4'd0:    r = 16'd12;
                    4'd1:    r = 16'd16;
                    4'd2:    r = 16'd24;
                    4'd3:    r = 16'd32;
                    4'd4:    r = 16'd64;
                    4'd5:    r = 16'd128;
                    4'd6:    r = 16'd256;
                    4'd7:    r = 16'd1024;
                    default: r = 16'd4096;
                endcase
            end
            default: begin
                case (idx)
                    4'd0:    r = 16'd64;
                    4'd1:    r = 16'd128;
                    4'd2:    r = 16'd320;
                    4'd3:    r = 16'd640;
                    4'd4:    r = 16'd1280;
                    4'd5:    r = 16'd3200;
                    4'd6:    r = 16'd6400;
                    4'd7:    r = 16'd12800;
                    default: r = 16'd32000;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic drv_en,
    output logic drv_val,
    output logic samp_hi,
    output logic samp_lo,
    output logic fin
);
    localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYC - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_HI;
            cnt_q <= '0;
        end else begin
            case (ph_q)
                PH_HI, PH_LO: begin
                    if (last) begin
                        cnt_q <= '0;
                        ph_q  <= (ph_q == PH_HI) ? PH_LO : PH_FIN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FIN:  ph_q <= PH_DONE;
                default: ph_q <= PH_DONE;
            endcase
        end
    end

    assign drv_en  = (ph_q == PH_HI) || (ph_q == PH_LO);
    assign drv_val = (ph_q == PH_HI);
    assign samp_hi = (ph_q == PH_HI) && last;
    assign samp_lo = (ph_q == PH_LO) && last;
    assign fin     = (ph_q == PH_FIN);
endmodule

// File: rtl/strap_pin_sense.sv
module strap_pin_sense
    import strap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    input  logic samp_hi,
    input  logic samp_lo,
    input  logic fin,
    input  logic done,
    output tri_e state_now,
    output logic hold_low
);
    logic hi_q;
    logic lo_q;
    tri_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
            st_q <= TRI_LO;
        end else begin
            if (samp_hi) hi_q <= pad_in;
            if (samp_lo) lo_q <= pad_in;
            if (fin)     st_q <= state_now;
        end
    end

    assign state_now = classify(hi_q, lo_q);
    assign hold_low  = done && (st_q == TRI_FL);
endmodule

// File: rtl/strap_decode.sv
module strap_decode
    import strap_pkg::*;
(
    input  logic [2*NUM_PINS-1:0] codes,
    output cfg_t                  cfg
);
    tri_e c_mode, c_speed, c_filt, c_rlo, c_rhi, c_lanes, c_hdr;

    assign c_mode  = tri_e'(codes[2*PIN_MODE  +: 2]);
    assign c_speed = tri_e'(codes[2*PIN_SPEED +: 2]);
    assign c_filt  = tri_e'(codes[2*PIN_FILT  +: 2]);
    assign c_rlo   = tri_e'(codes[2*PIN_RLO   +: 2]);
    assign c_rhi   = tri_e'(codes[2*PIN_RHI   +: 2]);
    assign c_lanes = tri_e'(codes[2*PIN_LANES +: 2]);
    assign c_hdr   = tri_e'(codes[2*PIN_HDR   +: 2]);

    always_comb begin
        cfg = CFG_RESET;
        if (c_mode == TRI_HI) begin
            cfg.spi = 1'b1;
        end else begin
            cfg.buf_en   = (c_mode == TRI_LO);
            cfg.speed    = c_speed;
            cfg.filt     = c_filt;
            cfg.osr      = osr_lookup(c_filt, pair_index(c_rhi, c_rlo));
            cfg.lanes    = c_lanes;
            cfg.hdr      = c_hdr;
            cfg.clk_ext  = 1'b1;
            cfg.ref_high = 1'b1;
            cfg.vcm_en   = 1'b1;
        end
    end
endmodule

// File: rtl/strap_sense_top.sv
module strap_sense_top
    import strap_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_drv_en,
    output logic [NUM_PINS-1:0] pad_drv_val,
    output logic [NUM_PINS-1:0] pad_hold_low,
    output logic                done,
    output logic                prog_spi,
    output logic                buf_en,
    output logic [1:0]          speed_sel,
    output logic [1:0]          filt_sel,
    output logic [RATIO_W-1:0]  osr_ratio,
    output logic [1:0]          lane_sel,
    output logic [1:0]          hdr_sel,
    output logic                clk_ext,
    output logic                ref_high,
    output logic                vcm_en
);
    logic drv_en, drv_val, samp_hi, samp_lo, fin;
    logic [2*NUM_PINS-1:0] codes;
    cfg_t cfg_dec, cfg_q;
    logic done_q;

    strap_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .drv_en  (drv_en),
        .drv_val (drv_val),
        .samp_hi (samp_hi),
        .samp_lo (samp_lo),
        .fin     (fin)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        tri_e st;
        strap_pin_sense u_pin (
            .clk       (clk),
            .rst       (rst),
            .pad_in    (pad_in[i]),
            .samp_hi   (samp_hi),
            .samp_lo   (samp_lo),
            .fin       (fin),
            .done      (done_q),
            .state_now (st),
            .hold_low  (pad_hold_low[i])
        );
        assign codes[2*i +: 2] = st;
    end

    strap_decode u_dec (
        .codes (codes),
        .cfg   (cfg_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            done_q <= 1'b0;
        end else if (fin) begin
            cfg_q  <= cfg_dec;
            done_q <= 1'b1;
        end
    end

    assign pad_drv_en  = {NUM_PINS{drv_en}};
    assign pad_drv_val = {NUM_PINS{drv_val}};
    assign done        = done_q;
    assign prog_spi    = cfg_q.spi;
    assign buf_en      = cfg_q.buf_en;
    assign speed_sel   = cfg_q.speed;
    assign filt_sel    = cfg_q.filt;
    assign osr_ratio   = cfg_q.osr;
    assign lane_sel    = cfg_q.lanes;
    assign hdr_sel     = cfg_q.hdr;
    assign clk_ext     = cfg_q.clk_ext;
    assign ref_high    = cfg_q.ref_high;
    assign vcm_en      = cfg_q.vcm_en;
endmodule

// File: rtl/strap_sense_sva.sv
module strap_sense_sva (
    input logic        clk,
    input logic        rst,
    input logic [6:0]  pad_drv_en,
    input logic [6:0]  pad_drv_val,
    input logic [6:0]  pad_hold_low,
    input logic        done,
    input logic        prog_spi,
    input logic        buf_en,
    input logic [1:0]  speed_sel,
    input logic [1:0]  filt_sel,
    input logic [15:0] osr_ratio,
    input logic [1:0]  lane_sel,
    input logic [1:0]  hdr_sel,
    input logic        clk_ext,
    input logic        ref_high,
    input logic        vcm_en
);
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable({prog_spi, buf_en, speed_sel, filt_sel, osr_ratio,
                                           lane_sel, hdr_sel, clk_ext, ref_high, vcm_en, pad_hold_low}));

    p_done_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_drive_uniform_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_drv_en != 7'd0) |-> (pad_drv_en == 7'h7f));

    p_drive_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (pad_drv_en == 7'd0));

    p_hold_after_done_r4: assert property (@(posedge clk) disable iff (rst)
        (pad_hold_low != 7'd0) |-> done);

    p_spi_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        (done && prog_spi) |-> (!buf_en && !clk_ext && speed_sel == 2'd0 && filt_sel == 2'd0
                                && osr_ratio == 16'd32 && lane_sel == 2'd0 && hdr_sel == 2'd0));

    p_reset_values_r6: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!prog_spi && !buf_en && !clk_ext && !ref_high && !vcm_en && speed_sel == 2'd0
                   && filt_sel == 2'd0 && osr_ratio == 16'd32 && lane_sel == 2'd0 && hdr_sel == 2'd0));

    p_hw_defaults_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !prog_spi) |-> (clk_ext && ref_high && vcm_en));
endmodule

bind strap_sense_top strap_sense_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .pad_drv_en   (pad_drv_en),
    .pad_drv_val  (pad_drv_val),
    .pad_hold_low (pad_hold_low),
    .done         (done),
    .prog_spi     (prog_spi),
    .buf_en       (buf_en),
    .speed_sel    (speed_sel),
    .filt_sel     (filt_sel),
    .osr_ratio    (osr_ratio),
    .lane_sel     (lane_sel),
    .hdr_sel      (hdr_sel),
    .clk_ext      (clk_ext),
    .ref_high     (ref_high),
    .vcm_en       (vcm_en)
);

// File: tb/strap_sense_tb_top.sv
module strap_sense_tb_top;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  pad_in;
    logic [6:0]  pad_drv_en, pad_drv_val, pad_hold_low;
    logic        done, prog_spi, buf_en, clk_ext, ref_high, vcm_en;
    logic [1:0]  speed_sel, filt_sel, lane_sel, hdr_sel;
    logic [15:0] osr_ratio;

    // Pad state per pin: 0 strong low, 1 strong high, 2 open.
    logic [1:0]  strap [7];
    int          total = 0;
    int          bad   = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 7; i++) begin
            case (strap[i])
                2'd0:    pad_in[i] = 1'b0;
                2'd1:    pad_in[i] = 1'b1;
                default: pad_in[i] = pad_hold_low[i] ? 1'b0 : (pad_drv_en[i] ? pad_drv_val[i] : 1'b0);
            endcase
        end
    end

    strap_sense_top #(.PULSE_CYC(P)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .pad_in       (pad_in),
        .pad_drv_en   (pad_drv_en),
        .pad_drv_val  (pad_drv_val),
        .pad_hold_low (pad_hold_low),
        .done         (done),
        .prog_spi     (prog_spi),
        .buf_en       (buf_en),
        .speed_sel    (speed_sel),
        .filt_sel     (filt_sel),
        .osr_ratio    (osr_ratio),
        .lane_sel     (lane_sel),
        .hdr_sel      (hdr_sel),
        .clk_ext      (clk_ext),
        .ref_high     (ref_high),
        .vcm_en       (vcm_en)
    );

    function automatic logic [15:0] ratio_ref(input logic [1:0] f, input int idx);
        int wb [9]  = '{32, 64, 128, 256, 512, 1024, 2048, 4096, 4096};
        int s4 [9]  = '{12, 16, 24, 32, 64, 128, 256, 1024, 4096};
        int s41 [9] = '{64, 128, 320, 640, 1280, 3200, 6400, 12800, 32000};
        if (f == 2'd0) return 16'(wb[idx]);
        if (f == 2'd1) return 16'(s4[idx]);
        return 16'(s41[idx]);
    endfunction

    // Packed order: spi, buf, speed, filt, osr, lanes, hdr, clk_ext, ref_high, vcm.
    function automatic logic [28:0] cfg_ref(input logic [1:0] s [7]);
        if (s[0] == 2'd1)
            return {1'b1, 1'b0, 2'd0, 2'd0, 16'd32, 2'd0, 2'd0, 3'b000};
        return {1'b0, (s[0] == 2'd0), s[1], s[2], ratio_ref(s[2], 3 * int'(s[4]) + int'(s[3])),
                s[5], s[6], 3'b111};
    endfunction

    function automatic logic [6:0] hold_ref(input logic [1:0] s [7]);
        logic [6:0] h;
        for (int i = 0; i < 7; i++) h[i] = (s[i] == 2'd2);
        return h;
    endfunction

    function automatic logic [28:0] cfg_now();
        return {prog_spi, buf_en, speed_sel, filt_sel, osr_ratio, lane_sel, hdr_sel,
                clk_ext, ref_high, vcm_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input int code);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s combo=%0d actual=%h expected=%h", req, code, act, exp);
        end
    endtask

    task automatic run_combo(input int code, input bit deep);
        logic [1:0] orig [7];
        int c = code;
        for (int i = 0; i < 7; i++) begin
            strap[i] = 2'(c % 3);
            c = c / 3;
        end
        orig = strap;
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int n = 1; n <= 2 * P + 1; n++) begin
            @(negedge clk);
            if (deep && n == 1) begin
                chk("R6 reset values", {3'b0, cfg_now()}, {3'b0, 1'b0, 1'b0, 4'd0, 16'd32, 4'd0, 3'b000}, code);
                chk("R4 no hold before done", {25'd0, pad_hold_low}, 32'd0, code);
                chk("R3 weak high pulse", {18'd0, pad_drv_en, pad_drv_val}, {18'd0, 7'h7f, 7'h7f}, code);
            end
            if (deep && n == P + 1)
                chk("R3 weak low pulse", {18'd0, pad_drv_en, pad_drv_val}, {18'd0, 7'h7f, 7'h00}, code);
            if (n == 2 * P)
                chk("R3 done not early", {31'd0, done}, 32'd0, code);
        end
        chk("R3 done timing", {31'd0, done}, 32'd1, code);
        chk("R3 drive released", {25'd0, pad_drv_en}, 32'd0, code);
        chk("R1 R5 R7 R8 R9 latched config", {3'b0, cfg_now()}, {3'b0, cfg_ref(orig)}, code);
        chk("R1 R4 float hold", {25'd0, pad_hold_low}, {25'd0, hold_ref(orig)}, code);
        if (deep) begin
            for (int i = 0; i < 7; i++) strap[i] = 2'($urandom % 3);
            repeat (5) @(negedge clk);
            chk("R2 late change ignored cfg", {3'b0, cfg_now()}, {3'b0, cfg_ref(orig)}, code);
            chk("R2 late change ignored hold", {25'd0, pad_hold_low}, {25'd0, hold_ref(orig)}, code);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 7; i++) strap[i] = 2'd0;
        repeat (3) @(negedge clk);
        // Directed corners: all low, all high, all open, hardware-mode with max ratio index.
        run_combo(0, 1'b1);
        run_combo(1093, 1'b1);
        run_combo(2186, 1'b1);
        run_combo(2 + 3 * 2 + 9 * 2 + 27 * 2 + 81 * 2, 1'b1);
        for (int code = 0; code < 2187; code++)
            run_combo(code, ($urandom % 6) == 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule